// File: doc/BRIEF.md
# LIN Header Detector

This block watches an already synchronized serial receive line and picks out the header of a LIN frame. It times a dominant (low) break by counting 16x oversampling ticks, and then counts the falling edges of the sync byte that follows. When the fifth falling edge arrives it reports sync and pulses a pointer reset to the receive FIFO, so the next byte lands in the first FIFO location.

The first identifier byte that the receiver delivers after sync is checked against its two parity bits. Each of the three events (break, sync, parity error) gives a one-cycle pulse and sets a sticky flag. A read strobe from the flag register clears all three flags. Baud-rate correction and response or checksum handling belong to other blocks.

Top module: `lin_hdr_detect`

## Requirements
- R1: `brk_evt` pulses once the line has been low for 184 oversampling ticks (11.5 bit times at 16 ticks per bit). A low period of 183 ticks gives no pulse. Clock cycles without `os_tick` do not count.
- R2: `brk_evt` fires at most once per low period, however long the line stays low.
- R3: After a break, the fifth falling edge on the line gives one `sync_evt` pulse. Falling edges that arrive without a preceding break never produce `sync_evt`.
- R4: `ptr_rst` pulses in exactly the cycles in which `sync_evt` pulses.
- R5: While it waits for sync edges, the edge counter disarms if the line stays high for 64 ticks with no falling edge. With 60 high ticks it stays armed.
- R6: For identifier byte b, the expected P0 is b0^b1^b2^b4 and the expected P1 is ~(b1^b3^b4^b5). P0 is bit 6 and P1 is bit 7. `perr_evt` pulses the cycle after `id_valid` when either received bit differs from its expected value.
- R7: Only the first byte after sync detection is checked. Later bytes, and bytes received without a prior sync, never produce `perr_evt`.
- R8: `flags` is sticky: bit 0 is break, bit 1 is sync and bit 2 is parity error. Each bit is set by its event pulse.
- R9: A `flag_rd` strobe clears all flags on the next edge. An event pulse in the same cycle as `flag_rd` leaves its own flag set.
- R10: After reset, all pulses and flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_in | input | 1 | Synchronized receive line, idle high |
| os_tick | input | 1 | 16x oversampling tick enable |
| id_byte | input | 8 | Received identifier byte |
| id_valid | input | 1 | Strobe marking `id_byte` valid |
| flag_rd | input | 1 | Flag register read strobe, clears the flags |
| brk_evt | output | 1 | Break detected pulse |
| sync_evt | output | 1 | Sync completed pulse |
| perr_evt | output | 1 | Identifier parity error pulse |
| ptr_rst | output | 1 | Receive FIFO pointer reset pulse |
| flags | output | 3 | Sticky flags {perr, sync, brk} |

## Verification
A read of the flag register can land in the same cycle as a new event pulse. In that case the clear and the set compete for the same flag bit. The bench provokes this by sending a bad identifier after a full header and raising `flag_rd` in the cycle where `perr_evt` is high. It then expects the flags to read back as only the parity-error bit, with break and sync cleared. A second read alone must then return zero.

// File: rtl/lin_hdr_pkg.sv
package lin_hdr_pkg;
  localparam int FLG_BRK  = 0;
  localparam int FLG_SYNC = 1;
  localparam int FLG_PERR = 2;
  localparam int FLG_W    = 3;

  // expected {P1, P0} for a 6-bit identifier
  function automatic logic [1:0] pid_bits(input logic [5:0] id);
    logic p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0};
  endfunction
endpackage

// File: rtl/lin_brk_timer.sv
module lin_brk_timer #(
  parameter int OSR           = 16,
  parameter int BRK_HALF_BITS = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic os_tick,
  output logic brk_evt
);
  localparam int THRESH = OSR * BRK_HALF_BITS / 2;
  localparam int CW     = $clog2(THRESH + 1);
  localparam logic [CW-1:0] THR_V  = CW'(THRESH);
  localparam logic [CW-1:0] THR_M1 = CW'(THRESH - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          evt_d;

  always_comb begin
    cnt_d = cnt_q;
    evt_d = 1'b0;
    if (rx_in) begin
      cnt_d = '0;
    end else if (os_tick && (cnt_q != THR_V)) begin
      cnt_d = cnt_q + 1'b1;
      evt_d = (cnt_q == THR_M1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      brk_evt <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      brk_evt <= evt_d;
    end
  end

  // R1
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |-> $past(!rx_in));
  // R2
  brk_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> !brk_evt);
endmodule

// File: rtl/lin_sync_counter.sv
module lin_sync_counter #(
  parameter int OSR      = 16,
  parameter int EDGES    = 5,
  parameter int TMO_BITS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  input  logic os_tick,
  input  logic arm,
  output logic sync_evt
);
  localparam int TMO = OSR * TMO_BITS;
  localparam int EW  = $clog2(EDGES + 1);
  localparam int TW  = $clog2(TMO + 1);
  localparam logic [EW-1:0] EDGE_LAST = EW'(EDGES - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO - 1);

  logic          rx_q;
  logic          armed_q, armed_d;
  logic [EW-1:0] ecnt_q, ecnt_d;
  logic [TW-1:0] tmo_q, tmo_d;
  logic          evt_d;
  logic          fall;

  assign fall = rx_q & ~rx_in;

  always_comb begin
    armed_d = armed_q;
    ecnt_d  = ecnt_q;
    tmo_d   = tmo_q;
    evt_d   = 1'b0;
    if (arm) begin
      armed_d = 1'b1;
      ecnt_d  = '0;
      tmo_d   = '0;
    end else if (armed_q) begin
      if (fall) begin
        tmo_d = '0;
        if (ecnt_q == EDGE_LAST) begin
          evt_d   = 1'b1;
          armed_d = 1'b0;
          ecnt_d  = '0;
        end else begin
          ecnt_d = ecnt_q + 1'b1;
        end
      end else if (os_tick && rx_in) begin
        if (tmo_q == TMO_LAST) begin
          armed_d = 1'b0;
          ecnt_d  = '0;
          tmo_d   = '0;
        end else begin
          tmo_d = tmo_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b1;
      armed_q  <= 1'b0;
      ecnt_q   <= '0;
      tmo_q    <= '0;
      sync_evt <= 1'b0;
    end else begin
      rx_q     <= rx_in;
      armed_q  <= armed_d;
      ecnt_q   <= ecnt_d;
      tmo_q    <= tmo_d;
      sync_evt <= evt_d;
    end
  end

  // R3
  sync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |-> $past(rx_q && !rx_in));
  // R3
  sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt);
endmodule

// File: rtl/lin_pid_check.sv
module lin_pid_check
  import lin_hdr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [7:0] id_byte,
  input  logic       id_valid,
  output logic       perr_evt
);
  logic armed_q, armed_d;
  logic evt_d;
  logic [1:0] exp_bits;

  assign exp_bits = pid_bits(id_byte[5:0]);

  always_comb begin
    armed_d = armed_q;
    evt_d   = 1'b0;
    if (arm) begin
      armed_d = 1'b1;
    end else if (armed_q && id_valid) begin
      armed_d = 1'b0;
      evt_d   = (exp_bits != id_byte[7:6]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      perr_evt <= 1'b0;
    end else begin
      armed_q  <= armed_d;
      perr_evt <= evt_d;
    end
  end

  // R6
  perr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |-> $past(id_valid));
  // R7
  perr_first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |-> !armed_q);
endmodule

// File: rtl/lin_hdr_detect.sv
module lin_hdr_detect
  import lin_hdr_pkg::*;
#(
  parameter int OSR           = 16,
  parameter int BRK_HALF_BITS = 23,
  parameter int SYNC_EDGES    = 5,
  parameter int TMO_BITS      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             os_tick,
  input  logic [7:0]       id_byte,
  input  logic             id_valid,
  input  logic             flag_rd,
  output logic             brk_evt,
  output logic             sync_evt,
  output logic             perr_evt,
  output logic             ptr_rst,
  output logic [FLG_W-1:0] flags
);
  logic [1:0]       rs_q;
  logic             rst_int_n;
  logic [FLG_W-1:0] flags_d, evt_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  lin_brk_timer #(.OSR(OSR), .BRK_HALF_BITS(BRK_HALF_BITS)) u_brk (
    .clk(clk), .rst_n(rst_int_n), .rx_in(rx_in), .os_tick(os_tick),
    .brk_evt(brk_evt));

  lin_sync_counter #(.OSR(OSR), .EDGES(SYNC_EDGES), .TMO_BITS(TMO_BITS)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .rx_in(rx_in), .os_tick(os_tick),
    .arm(brk_evt), .sync_evt(sync_evt));

  lin_pid_check u_pid (
    .clk(clk), .rst_n(rst_int_n), .arm(sync_evt), .id_byte(id_byte),
    .id_valid(id_valid), .perr_evt(perr_evt));

  assign ptr_rst = sync_evt;

  always_comb begin
    evt_vec           = '0;
    evt_vec[FLG_BRK]  = brk_evt;
    evt_vec[FLG_SYNC] = sync_evt;
    evt_vec[FLG_PERR] = perr_evt;
    flags_d = (flag_rd ? '0 : flags) | evt_vec;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flags <= '0;
    else            flags <= flags_d;
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (brk_evt || sync_evt || perr_evt) |=>
      (flags[FLG_BRK] || !$past(brk_evt)) && (flags[FLG_SYNC] || !$past(sync_evt))
      && (flags[FLG_PERR] || !$past(perr_evt)));
  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_rd && !brk_evt && !sync_evt && !perr_evt) |=> (flags == '0));
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!flag_rd && !brk_evt && !sync_evt && !perr_evt) |=> $stable(flags));
endmodule

// File: tb/test_lin_hdr_detect.sv
module test_lin_hdr_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_in;
  logic       os_tick;
  logic [7:0] id_byte;
  logic       id_valid;
  logic       flag_rd;
  logic       brk_evt, sync_evt, perr_evt, ptr_rst;
  logic [2:0] flags;

  int checks = 0;
  int errors = 0;
  int n_brk = 0, n_sync = 0, n_perr = 0, n_ptr = 0, n_mis = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_hdr_detect i_lin_hdr_detect (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
    .id_byte(id_byte), .id_valid(id_valid), .flag_rd(flag_rd),
    .brk_evt(brk_evt), .sync_evt(sync_evt), .perr_evt(perr_evt),
    .ptr_rst(ptr_rst), .flags(flags));

  always @(negedge clk) begin
    if (brk_evt)  n_brk++;
    if (sync_evt) n_sync++;
    if (perr_evt) n_perr++;
    if (ptr_rst)  n_ptr++;
    if (ptr_rst != sync_evt) n_mis++;
  end

  function automatic logic [7:0] mk_pid(input logic [5:0] id);
    logic a, b;
    a = id[0] ^ id[1] ^ id[2] ^ id[4];
    b = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {b, a, id};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rx_in = v;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic send_frame(input logic [7:0] b);
    hold(1'b0, 16);
    for (int i = 0; i < 8; i++) hold(b[i], 16);
    hold(1'b1, 16);
  endtask

  task automatic send_id(input logic [7:0] b);
    id_byte = b; id_valid = 1'b1;
    @(posedge clk); #1;
    id_valid = 1'b0;
    hold(1'b1, 4);
  endtask

  task automatic read_flags();
    flag_rd = 1'b1;
    @(posedge clk); #1;
    flag_rd = 1'b0;
  endtask

  task automatic header();
    hold(1'b0, 200);
    hold(1'b1, 16);
    send_frame(8'h55);
    hold(1'b1, 4);
  endtask

  task automatic t_reset();
    check(flags == 3'b000, "R10 flags", flags, 0);
    check({brk_evt, sync_evt, perr_evt, ptr_rst} == 4'b0, "R10 pulses",
          {brk_evt, sync_evt, perr_evt, ptr_rst}, 0);
  endtask

  task automatic t_break_len();
    int b0;
    b0 = n_brk;
    hold(1'b0, 183); hold(1'b1, 4);
    check(n_brk == b0, "R1 183 ticks", n_brk - b0, 0);
    hold(1'b0, 400); hold(1'b1, 4);
    check(n_brk == b0 + 1, "R2 once per low", n_brk - b0, 1);
    check(flags[0] == 1'b1, "R8 brk flag", flags[0], 1);
    read_flags();
    check(flags == 3'b000, "R9 read clears", flags, 0);
  endtask

  task automatic t_tick_gaps();
    int b0;
    b0 = n_brk;
    rx_in = 1'b0;
    for (int i = 0; i < 366; i++) begin
      os_tick = (i % 2 == 0);
      @(posedge clk); #1;
    end
    check(n_brk == b0, "R1 183 gapped ticks", n_brk - b0, 0);
    os_tick = 1'b1;
    @(posedge clk); #1;
    hold(1'b1, 3);
    check(n_brk == b0 + 1, "R1 184th tick", n_brk - b0, 1);
    read_flags();
  endtask

  task automatic t_sync_good();
    int s0, p0, e0;
    s0 = n_sync; p0 = n_ptr; e0 = n_perr;
    header();
    check(n_sync == s0 + 1, "R3 fifth edge", n_sync - s0, 1);
    check(n_ptr == p0 + 1, "R4 ptr pulse", n_ptr - p0, 1);
    check(n_mis == 0, "R4 same cycle", n_mis, 0);
    send_id(mk_pid(6'h12));
    check(n_perr == e0, "R6 good pid", n_perr - e0, 0);
    check(flags == 3'b011, "R8 brk+sync flags", flags, 3);
    read_flags();
  endtask

  task automatic t_perr();
    int e0;
    e0 = n_perr;
    header();
    send_id(mk_pid(6'h2B) ^ 8'h40);
    check(n_perr == e0 + 1, "R6 bad P0", n_perr - e0, 1);
    check(flags[2] == 1'b1, "R8 perr flag", flags[2], 1);
    send_id(mk_pid(6'h2B) ^ 8'h80);
    check(n_perr == e0 + 1, "R7 second byte ignored", n_perr - e0, 1);
    read_flags();
    header();
    send_id(mk_pid(6'h05) ^ 8'h80);
    check(n_perr == e0 + 2, "R6 bad P1", n_perr - e0, 2);
    read_flags();
  endtask

  task automatic t_no_break();
    int s0, e0;
    s0 = n_sync; e0 = n_perr;
    send_frame(8'h55);
    hold(1'b1, 4);
    check(n_sync == s0, "R3 no break no sync", n_sync - s0, 0);
    send_id(8'h00);
    check(n_perr == e0, "R7 no sync no check", n_perr - e0, 0);
    read_flags();
  endtask

  task automatic t_timeout();
    int s0;
    s0 = n_sync;
    hold(1'b0, 200); hold(1'b1, 80);
    send_frame(8'h55); hold(1'b1, 4);
    check(n_sync == s0, "R5 timed out", n_sync - s0, 0);
    hold(1'b0, 200); hold(1'b1, 60);
    send_frame(8'h55); hold(1'b1, 4);
    check(n_sync == s0 + 1, "R5 within window", n_sync - s0, 1);
    read_flags();
  endtask

  task automatic t_coincide();
    header();
    id_byte = mk_pid(6'h33) ^ 8'h40; id_valid = 1'b1;
    @(posedge clk); #1;
    id_valid = 1'b0;
    flag_rd = 1'b1;
    @(posedge clk); #1;
    flag_rd = 1'b0;
    check(flags == 3'b100, "R9 event beats clear", flags, 4);
    read_flags();
    check(flags == 3'b000, "R9 later clear", flags, 0);
  endtask

  initial begin
    rst_n = 1'b0; rx_in = 1'b1; os_tick = 1'b1;
    id_byte = '0; id_valid = 1'b0; flag_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) begin @(posedge clk); #1; end
    t_reset();
    t_break_len();
    t_tick_gaps();
    t_sync_good();
    t_perr();
    t_no_break();
    t_timeout();
    t_coincide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule